// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block drives outgoing frames from four host-owned transmit slots. Each slot pairs a 32-bit buffer base address with a 32-bit command/status word. The host writes the base, then writes the command word with a nonzero byte count. That write hands the slot to the engine. The engine works through the slots in a fixed circular order. It fetches the frame bytes one at a time from a memory read port into a small byte FIFO. It then plays them out on a byte-wide transmit stream that cannot be stalled.

Each slot carries its own start threshold, counted in 32-byte units. Output holds back until that many bytes sit in the FIFO, or the whole frame does if it is shorter, or the FIFO is full. This trades start latency against the risk of running dry when memory is slow. A frame finishes in one of two ways:
- Success: the slot's completion flag and the good-completion interrupt bit are set.
- Underrun: the FIFO empties in mid-frame. The frame is cut short, and the slot's underrun flag and the error interrupt bit are set.

Both interrupt bits are cleared by writing ones to them.

Top module: `txdesc_engine`

## Requirements
- R1: After reset every slot word, every base register and the interrupt status read 0, and `tx_valid` and `mem_req` are 0.
- R2: Slot i's command/status word sits at byte offset 0x10+4*i and its base address at 0x20+4*i; the interrupt status sits at 0x3C. The command/status word holds byte count in [12:0], fetched-all flag in [13], underrun flag in [14], good-completion flag in [15] and threshold in [21:16]; bits [31:22] read 0.
- R3: A command write with a nonzero byte count to an idle slot queues it; a write with byte count 0 stores the fields but starts no frame.
- R4: While a slot is queued or in flight, writes to its command word and its base register are ignored.
- R5: Frames are served strictly in slot order 0,1,2,3,0,...; the engine waits on the next slot in order even if a later slot is queued.
- R6: A frame emits bytes from memory addresses base..base+count-1 in order, one per `tx_valid` cycle, with `tx_last` on the final byte.
- R7: Output starts only once the FIFO holds min(threshold*32, count, FIFO depth) bytes; a threshold of 0 means one byte.
- R8: The fetched-all flag sets when the frame's last byte returns from memory and clears on the next accepted command write to that slot.
- R9: A frame that ends normally sets the slot's good-completion flag and interrupt bit 2.
- R10: If the FIFO is empty while a frame is being sent, the frame ends without `tx_last`. The underrun flag and interrupt bit 3 are set, and the good-completion flag stays 0.
- R11: Writing 1 to interrupt bit 2 or 3 clears it, and writing 0 leaves it. A new event in the same cycle wins over the clear.
- R12: The cycle after a `tx_last` byte never carries `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 32 | Memory byte address |
| mem_gnt | input | 1 | Request accepted this cycle; data follows one cycle later |
| mem_rdata | input | 8 | Memory read data |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a successfully completed frame |

## Verification
A vector table sends one frame through each slot with a permanently granted memory port. It covers a single-byte frame, odd counts, a count that exactly fills the FIFO, and thresholds of 0, 1, 2 and 63. This separates the three terms of the start rule and checks addressing across byte-carry boundaries. With a memory that grants only every other cycle, a frame fully buffered by its threshold must complete, and one with a low threshold must underrun. This outcome pair shows that the threshold really gates output. Out-of-order queueing, writes to a stalled busy slot, count-0 writes and a measured start latency tell apart the slot-order, ignore, launch and threshold rules.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int NSLOT  = 4;
    localparam int IDX_W  = $clog2(NSLOT);
    localparam int SIZE_W = 13;
    localparam int THR_W  = 6;

    localparam logic [7:0] STAT_BASE = 8'h10;
    localparam logic [7:0] BASE_BASE = 8'h20;
    localparam logic [7:0] IRQ_OFF   = 8'h3C;
    localparam int IRQ_OK_BIT  = 2;
    localparam int IRQ_ERR_BIT = 3;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_FILL = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [31:0]       base;
        logic [SIZE_W-1:0] size;
        logic [THR_W-1:0]  thr;
        logic              own;
        logic              urun;
        logic              ok;
        logic              busy;
    } slot_t;

    function automatic logic [7:0] stat_off(input int i);
        return STAT_BASE + 8'(4 * i);
    endfunction

    function automatic logic [7:0] base_off(input int i);
        return BASE_BASE + 8'(4 * i);
    endfunction

    function automatic logic [31:0] pack_status(input slot_t s);
        return {10'b0, s.thr, s.ok, s.urun, s.own, s.size};
    endfunction

    // bytes that must sit in the FIFO before output may begin
    function automatic logic [SIZE_W-1:0] start_need(
        input logic [SIZE_W-1:0] size,
        input logic [THR_W-1:0]  thr,
        input logic [SIZE_W-1:0] depth
    );
        logic [SIZE_W-1:0] n;
        n = {2'b00, thr, 5'b00000};
        if (thr == '0) n = SIZE_W'(1);
        if (n > size)  n = size;
        if (n > depth) n = depth;
        return n;
    endfunction

endpackage

// File: rtl/txd_fifo.sv
module txd_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic             empty
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign dout  = store[rd_ptr];
    assign empty = (cnt == '0);

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             ev_fetched,
    input  logic             ev_ok,
    input  logic             ev_urun,
    output slot_t            cur_slot,
    output logic             isr_ok,
    output logic             isr_err
);
    slot_t [NSLOT-1:0] slot_vec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        slot_t s_q;
        logic  is_cur, stat_hit, base_hit;

        assign is_cur   = (cur_idx == IDX_W'(g));
        assign stat_hit = we && (addr == stat_off(g));
        assign base_hit = we && (addr == base_off(g));
        assign slot_vec[g] = s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (s_q.busy) begin
                if (is_cur && ev_fetched) s_q.own <= 1'b1;
                if (is_cur && (ev_ok || ev_urun)) begin
                    s_q.busy <= 1'b0;
                    s_q.ok   <= ev_ok;
                    s_q.urun <= ev_urun;
                end
            end else begin
                if (stat_hit) begin
                    s_q.size <= wdata[SIZE_W-1:0];
                    s_q.thr  <= wdata[16 +: THR_W];
                    s_q.own  <= 1'b0;
                    s_q.ok   <= 1'b0;
                    s_q.urun <= 1'b0;
                    s_q.busy <= |wdata[SIZE_W-1:0];
                end
                if (base_hit) s_q.base <= wdata;
            end
        end
    end

    assign cur_slot = slot_vec[cur_idx];

    logic irq_hit;
    assign irq_hit = we && (addr == IRQ_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_ok  <= 1'b0;
            isr_err <= 1'b0;
        end else begin
            isr_ok  <= ev_ok   | (isr_ok  & ~(irq_hit & wdata[IRQ_OK_BIT]));
            isr_err <= ev_urun | (isr_err & ~(irq_hit & wdata[IRQ_ERR_BIT]));
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == IRQ_OFF) rdata = 32'({isr_err, isr_ok}) << IRQ_OK_BIT;
        for (int i = 0; i < NSLOT; i++) begin
            if (addr == stat_off(i)) rdata = pack_status(slot_vec[i]);
            if (addr == base_off(i)) rdata = slot_vec[i].base;
        end
    end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            cur_slot,
    output logic [IDX_W-1:0] cur_idx,
    input  logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    input  logic             fifo_empty,
    output logic             fifo_clr,
    output logic             push,
    output logic             pop,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_gnt,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             ev_fetched,
    output logic             ev_ok,
    output logic             ev_urun
);
    tx_state_e         state;
    logic [SIZE_W-1:0] fetch_cnt, sent_cnt, need;
    logic              rd_pend, active, room, issue;

    assign active   = (state != TX_IDLE);
    assign fifo_clr = !active;
    assign push     = rd_pend && active;
    assign room     = (int'(fifo_cnt) + int'(rd_pend)) < DEPTH;
    assign mem_req  = active && (fetch_cnt != cur_slot.size) && room;
    assign mem_addr = cur_slot.base + 32'(fetch_cnt);
    assign issue    = mem_req && mem_gnt;
    assign need     = start_need(cur_slot.size, cur_slot.thr, SIZE_W'(DEPTH));

    assign pop        = (state == TX_SEND) && !fifo_empty;
    assign tx_valid   = pop;
    assign tx_last    = pop && (sent_cnt == cur_slot.size - SIZE_W'(1));
    assign ev_ok      = tx_last;
    assign ev_urun    = (state == TX_SEND) && fifo_empty;
    assign ev_fetched = push && (fetch_cnt == cur_slot.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            cur_idx   <= '0;
            fetch_cnt <= '0;
            sent_cnt  <= '0;
            rd_pend   <= 1'b0;
        end else begin
            rd_pend <= issue;
            if (issue) fetch_cnt <= fetch_cnt + SIZE_W'(1);
            if (pop)   sent_cnt  <= sent_cnt + SIZE_W'(1);
            case (state)
                TX_IDLE: begin
                    if (cur_slot.busy) begin
                        state     <= TX_FILL;
                        fetch_cnt <= '0;
                        sent_cnt  <= '0;
                    end
                end
                TX_FILL: begin
                    if (SIZE_W'(fifo_cnt) >= need) state <= TX_SEND;
                end
                TX_SEND: begin
                    if (ev_ok || ev_urun) begin
                        state   <= TX_IDLE;
                        cur_idx <= cur_idx + IDX_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txd_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    slot_t             cur_slot;
    logic [IDX_W-1:0]  cur_idx;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_empty, fifo_clr, push, pop;
    logic              ev_fetched, ev_ok, ev_urun, isr_ok, isr_err;

    txd_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .cur_idx(cur_idx), .ev_fetched(ev_fetched),
        .ev_ok(ev_ok), .ev_urun(ev_urun), .cur_slot(cur_slot),
        .isr_ok(isr_ok), .isr_err(isr_err)
    );

    txd_seq #(.DEPTH(FIFO_DEPTH)) u_seq (
        .clk(clk), .rst(rst), .cur_slot(cur_slot), .cur_idx(cur_idx),
        .fifo_cnt(fifo_cnt), .fifo_empty(fifo_empty), .fifo_clr(fifo_clr),
        .push(push), .pop(pop), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .tx_valid(tx_valid), .tx_last(tx_last),
        .ev_fetched(ev_fetched), .ev_ok(ev_ok), .ev_urun(ev_urun)
    );

    txd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr), .push(push), .din(mem_rdata),
        .pop(pop), .dout(tx_data), .cnt(fifo_cnt), .empty(fifo_empty)
    );
endmodule

// File: rtl/txd_checker.sv
module txd_checker
    import txd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        tx_valid,
    input logic        tx_last,
    input logic        ev_ok,
    input logic        ev_urun,
    input logic        isr_ok
);
    logic clr_ok;
    assign clr_ok = reg_we && (reg_addr == IRQ_OFF) && reg_wdata[IRQ_OK_BIT];

    AST_LAST_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);                                   // R6
    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_last) |=> !tx_valid);                    // R12
    AST_URUN_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
        ev_urun |-> !tx_valid);                                  // R10
    AST_ONE_ENDING: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_ok, ev_urun}));                             // R9
    AST_OK_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        ev_ok |=> isr_ok);                                       // R9
    AST_IRQ_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && !ev_ok) |=> !isr_ok);                         // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (isr_ok && !clr_ok) |=> isr_ok);                         // R11
endmodule

bind txdesc_engine txd_checker u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_last(tx_last),
    .ev_ok(ev_ok), .ev_urun(ev_urun), .isr_ok(isr_ok)
);

// File: tb/txdesc_engine_tb.sv
module txdesc_engine_tb;
    localparam logic [7:0] STAT = 8'h10;
    localparam logic [7:0] BASE = 8'h20;
    localparam logic [7:0] IRQ  = 8'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_gnt = 1'b1;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;

    txdesc_engine u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    int gmode = 0;              // 0 always grant, 1 alternate, 2 hold off
    logic [7:0] byte_buf [0:8191];
    int byte_cnt = 0, frame_cnt = 0, gap_err = 0, first_tx = 0;
    logic prev_last = 1'b0, lat_arm = 1'b0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16];
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt) mem_rdata <= pat(mem_addr);
    end

    always @(negedge clk) begin
        case (gmode)
            0:       mem_gnt <= 1'b1;
            1:       mem_gnt <= ~mem_gnt;
            default: mem_gnt <= 1'b0;
        endcase
        if (prev_last && tx_valid) gap_err++;
        prev_last <= tx_valid && tx_last;
        if (tx_valid) begin
            byte_buf[byte_cnt] = tx_data;
            byte_cnt++;
            if (tx_last) frame_cnt++;
            if (lat_arm) begin first_tx = cyc; lat_arm = 1'b0; end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output logic [31:0] v);
        v = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(IRQ, v);
            if (v[3:2] != 2'b00) break;
        end
    endtask

    function automatic logic [31:0] cmd(input int size, input int thr);
        return 32'(size) | (32'(thr) << 16);
    endfunction

    task automatic check_bytes(input string req, input int st,
                               input logic [31:0] base, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (byte_buf[st + k] !== pat(base + 32'(k))) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    localparam int NV = 4;
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_23FE, 32'hABCD_00F0, 32'h0000_0010};
    localparam int V_SIZE [NV] = '{1, 37, 100, 64};
    localparam int V_THR  [NV] = '{0, 1, 63, 2};

    logic [31:0] v, s;
    int st, fr;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(STAT, v);        chk("R1 slot0 word", v, 0);
        rd(BASE + 8'd12, v);chk("R1 slot3 base", v, 0);
        rd(IRQ, v);         chk("R1 irq", v, 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        // table: one frame per slot, memory always granted (R2 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            st = byte_cnt; fr = frame_cnt;
            wr(BASE + 8'(4 * i), V_BASE[i]);
            rd(BASE + 8'(4 * i), v); chk("R2 base readback", v, V_BASE[i]);
            wr(STAT + 8'(4 * i), cmd(V_SIZE[i], V_THR[i]));
            wait_irq(v);
            chk("R9 irq bit2", v, 32'h4);
            chk("R6 byte count", 32'(byte_cnt - st), 32'(V_SIZE[i]));
            chk("R6 frame end", 32'(frame_cnt - fr), 1);
            check_bytes("R6 byte data", st, V_BASE[i], V_SIZE[i]);
            rd(STAT + 8'(4 * i), s);
            chk("R2 R8 R9 status word", s, cmd(V_SIZE[i], V_THR[i]) | 32'h0000_A000);
            wr(IRQ, 32'h4);
        end

        // R5: later slots queued while slot 0 idle must wait
        st = byte_cnt; fr = frame_cnt;
        wr(BASE + 8'd4, 32'h300); wr(STAT + 8'd4, cmd(11, 0));
        wr(BASE + 8'd8, 32'h400); wr(STAT + 8'd8, cmd(12, 1));
        repeat (60) @(negedge clk);
        chk("R5 waits for slot0", 32'(byte_cnt - st), 0);
        wr(BASE, 32'h200); wr(STAT, cmd(10, 0));
        for (int i = 0; i < 3000 && frame_cnt < fr + 3; i++) @(negedge clk);
        chk("R5 three frames", 32'(frame_cnt - fr), 3);
        check_bytes("R5 slot0 first", st, 32'h200, 10);
        check_bytes("R5 slot1 second", st + 10, 32'h300, 11);
        check_bytes("R5 slot2 third", st + 21, 32'h400, 12);
        chk("R12 idle gap", 32'(gap_err), 0);
        wr(IRQ, 32'hC);

        // R4 / R8: slot3 stalled by memory, writes ignored
        gmode = 2;
        st = byte_cnt;
        wr(BASE + 8'd12, 32'h500); wr(STAT + 8'd12, cmd(20, 0));
        repeat (10) @(negedge clk);
        wr(STAT + 8'd12, cmd(5, 3));
        wr(BASE + 8'd12, 32'h9999);
        rd(STAT + 8'd12, s); chk("R4 busy word kept, R8 own clear", s, cmd(20, 0));
        rd(BASE + 8'd12, s); chk("R4 busy base kept", s, 32'h500);
        gmode = 0;
        wait_irq(v);
        chk("R4 original count sent", 32'(byte_cnt - st), 20);
        check_bytes("R4 original base used", st, 32'h500, 20);
        rd(STAT + 8'd12, s); chk("R8 own after fetch", s[13], 1);
        // R11 write-one-to-clear
        wr(IRQ, 32'h0); rd(IRQ, v); chk("R11 zero write keeps", v, 32'h4);
        wr(IRQ, 32'h4); rd(IRQ, v); chk("R11 one write clears", v, 32'h0);

        // R7 start latency, slot0, threshold 1 -> 32 bytes
        wr(BASE, 32'h800);
        @(negedge clk); lat_arm = 1'b1;
        wr(STAT, cmd(100, 1));
        st = cyc;
        wait_irq(v);
        chk("R7 latency lower", 32'((first_tx - st) >= 33), 1);
        chk("R7 latency upper", 32'((first_tx - st) <= 40), 1);
        chk("R9 irq after gated start", v, 32'h4);
        wr(IRQ, 32'h4);

        // R7: slow memory, threshold covers frame -> no underrun
        gmode = 1;
        st = byte_cnt;
        wr(BASE + 8'd4, 32'h900); wr(STAT + 8'd4, cmd(48, 2));
        wait_irq(v);
        chk("R7 buffered frame ok", v, 32'h4);
        check_bytes("R7 buffered bytes", st, 32'h900, 48);
        wr(IRQ, 32'h4);

        // R10: slow memory, low threshold -> underrun
        st = byte_cnt; fr = frame_cnt;
        wr(BASE + 8'd8, 32'hA00); wr(STAT + 8'd8, cmd(200, 1));
        wait_irq(v);
        gmode = 0;
        chk("R10 irq bit3", v, 32'h8);
        chk("R10 cut short", 32'((byte_cnt - st) < 200), 1);
        chk("R10 no last", 32'(frame_cnt - fr), 0);
        rd(STAT + 8'd8, s);
        chk("R10 underrun set ok clear", {30'b0, s[15], s[14]}, 32'h1);
        wr(IRQ, 32'h8); rd(IRQ, v); chk("R11 error bit clears", v, 0);

        // R3: count-0 write to the slot next in order starts nothing
        st = byte_cnt;
        wr(STAT + 8'd12, cmd(0, 4));
        repeat (40) @(negedge clk);
        chk("R3 count 0 no frame", 32'(byte_cnt - st), 0);
        rd(STAT + 8'd12, s); chk("R3 fields stored", s, cmd(0, 4));
        // R8: next write clears own and flags
        wr(STAT + 8'd8, cmd(0, 0));
        rd(STAT + 8'd8, s); chk("R8 write clears flags", s, 0);
        rd(IRQ, v); chk("R3 no irq", v, 0);

        summary();
    end
endmodule